// File: doc/BRIEF.md
# Receive Sample-Phase Tuning Sweep

This block finds a good receive sampling phase for a card interface clock. A start request launches a sweep over all eight phase positions. For each position, the block first issues a strobe that loads the data timeout with all ones. It then asks an external command engine for one tuning-block transfer and waits for that engine to report pass or fail. Each pass is recorded in an eight-bit bitmap indexed by phase.

When every phase has been tried, the block chooses a phase from the bitmap. It prefers the centre of a circular run of five passing phases. Failing that, it takes the centre of a run of three. Failing that, it takes any passing phase. Where several phases qualify at the same level, the lowest index wins. The chosen phase goes to the sample-select register and is also held as the tuned sample. If no phase passed, the block flags an error. In that case the sample select ends on the phase it started from and the tuned sample keeps its old value.

Top module: `phase_tuner`

## Requirements
- R1: After reset, the sample select and the tuned sample are 0, and the request, timeout-load, done and error outputs are low.
- R2: A sweep started with current phase c tries the phases c+1, c+2, ... modulo 8 and ends with c. Each phase is tried exactly once, in eight trials, and the sample select shows the phase under trial while its request is out.
- R3: Each trial request comes in the cycle right after a one-cycle timeout-load strobe, and the timeout value output then reads all ones.
- R4: Only one trial is outstanding at a time. No further request is issued until a result strobe arrives.
- R5: The bitmap has bit p set when the trial at phase p passed. If some phase i has phases i-2 to i+2 (circular) all passing, the lowest such i is chosen.
- R6: If no five-wide run exists but some phase i has i-1, i and i+1 (circular) all passing, the lowest such i is chosen.
- R7: If neither run exists, the lowest passing phase is chosen.
- R8: If no phase passed, error is high together with done. The sample select equals the start phase c, and the tuned sample is unchanged.
- R9: Done is a one-cycle pulse, issued two cycles after the final result strobe. The sample select and the tuned sample hold the chosen phase from that same cycle.
- R10: A start request made while a sweep is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sweep (taken when idle) |
| cur_phase_i | input | 3 | Current sample phase, read at start |
| res_vld_i | input | 1 | Trial result strobe |
| res_pass_i | input | 1 | Trial passed, valid with res_vld_i |
| tmo_wr_o | output | 1 | Load the data timeout |
| tmo_val_o | output | 32 | Timeout value (all ones) |
| trial_req_o | output | 1 | Request one tuning transfer |
| phase_sel_o | output | 3 | Sample-select register |
| tuned_o | output | 3 | Held tuned sample |
| done_o | output | 1 | Sweep finished, one cycle |
| err_o | output | 1 | No passing phase, valid with done_o |

## Verification
The timeout-load strobe is due one cycle after the start is seen, and the request follows in the next cycle. The next strobe comes one cycle after a result strobe, unless that was the last trial. Done, error, the new sample select and the tuned sample are due two cycles after the final result. The bench drives inputs and samples on the falling edge. It counts those exact edges and checks both the cycle before done and the cycle after it, which pins down both the timing and the single-cycle pulse. Result strobes are delayed by different amounts, so the bench can confirm that no request appears while a trial is outstanding.

// File: rtl/phase_tuner.sv
module phase_tuner #(
  parameter int PW    = 3,
  parameter int TMO_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [PW-1:0] cur_phase_i,
  input  logic          res_vld_i,
  input  logic          res_pass_i,
  output logic          tmo_wr_o,
  output logic [TMO_W-1:0] tmo_val_o,
  output logic          trial_req_o,
  output logic [PW-1:0] phase_sel_o,
  output logic [PW-1:0] tuned_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int NPH = 1 << PW;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_REQ, S_WAIT, S_SEL} st_t;
  st_t st_q;

  logic [PW-1:0]  start_q;
  logic [NPH-1:0] pass_q;
  logic           done_q, err_q;

  logic          hit5, hit3, hit1;
  logic [PW-1:0] c5, c3, c1, pick;

  assign tmo_wr_o    = (st_q == S_ARM);
  assign tmo_val_o   = '1;
  assign trial_req_o = (st_q == S_REQ);
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_comb begin
    hit5 = 1'b0; hit3 = 1'b0; hit1 = 1'b0;
    c5 = '0; c3 = '0; c1 = '0;
    for (int i = NPH-1; i >= 0; i--) begin
      if (pass_q[i] && pass_q[(i+1)%NPH] && pass_q[(i+2)%NPH] &&
          pass_q[(i+NPH-1)%NPH] && pass_q[(i+NPH-2)%NPH]) begin
        hit5 = 1'b1; c5 = PW'(i);
      end
      if (pass_q[i] && pass_q[(i+1)%NPH] && pass_q[(i+NPH-1)%NPH]) begin
        hit3 = 1'b1; c3 = PW'(i);
      end
      if (pass_q[i]) begin
        hit1 = 1'b1; c1 = PW'(i);
      end
    end
    pick = hit5 ? c5 : hit3 ? c3 : c1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      start_q     <= '0;
      pass_q      <= '0;
      phase_sel_o <= '0;
      tuned_o     <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          start_q     <= cur_phase_i;
          phase_sel_o <= cur_phase_i + 1'b1;
          pass_q      <= '0;
          st_q        <= S_ARM;
        end
        S_ARM:  st_q <= S_REQ;
        S_REQ:  st_q <= S_WAIT;
        S_WAIT: if (res_vld_i) begin
          if (res_pass_i) pass_q[phase_sel_o] <= 1'b1;
          if (phase_sel_o == start_q) st_q <= S_SEL;
          else begin
            phase_sel_o <= phase_sel_o + 1'b1;
            st_q        <= S_ARM;
          end
        end
        S_SEL: begin
          done_q <= 1'b1;
          err_q  <= ~hit1;
          if (hit1) begin
            phase_sel_o <= pick;
            tuned_o     <= pick;
          end
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_tuner_chk.sv
module phase_tuner_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmo_wr_o,
  input logic          trial_req_o,
  input logic          res_vld_i,
  input logic [PW-1:0] phase_sel_o,
  input logic [PW-1:0] tuned_o,
  input logic          done_o,
  input logic          err_o
);
  logic outst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= 1'b0;
    else if (trial_req_o) outst_q <= 1'b1;
    else if (res_vld_i) outst_q <= 1'b0;
  end

  AST_REQ_AFTER_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req_o |-> $past(tmo_wr_o));                               // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !tmo_wr_o && !trial_req_o);                         // R4
  AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    trial_req_o |=> $stable(phase_sel_o));                          // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                            // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);                                              // R8
  AST_TUNED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> tuned_o == phase_sel_o);                 // R9
endmodule

bind phase_tuner phase_tuner_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmo_wr_o(tmo_wr_o), .trial_req_o(trial_req_o),
  .res_vld_i(res_vld_i), .phase_sel_o(phase_sel_o), .tuned_o(tuned_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/phase_tuner_test.sv
module phase_tuner_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, res_vld_i = 1'b0, res_pass_i = 1'b0;
  logic [2:0] cur_phase_i = '0;
  logic tmo_wr_o, trial_req_o, done_o, err_o;
  logic [31:0] tmo_val_o;
  logic [2:0] phase_sel_o, tuned_o;

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_tuner uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cur_phase_i(cur_phase_i),
    .res_vld_i(res_vld_i), .res_pass_i(res_pass_i), .tmo_wr_o(tmo_wr_o),
    .tmo_val_o(tmo_val_o), .trial_req_o(trial_req_o), .phase_sel_o(phase_sel_o),
    .tuned_o(tuned_o), .done_o(done_o), .err_o(err_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic sweep(input logic [2:0] cur, input logic [7:0] map, input int dly,
                       input logic [2:0] exp_ph, input bit exp_err,
                       input logic [2:0] exp_tuned, input bit poke_start);
    logic [2:0] expect_ph;
    int w;
    @(negedge clk);
    cur_phase_i = cur; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < 8; t++) begin
      expect_ph = cur + 3'(t + 1);
      w = 0;
      while (!tmo_wr_o && w < 20) begin @(negedge clk); w++; end
      chk(tmo_wr_o === 1'b1, "R3 tmo strobe", tmo_wr_o, 1);
      chk(tmo_val_o === '1, "R3 tmo value", tmo_val_o, 32'hFFFFFFFF);
      chk(trial_req_o === 1'b0, "R3 no req with tmo", trial_req_o, 0);
      @(negedge clk);
      chk(trial_req_o === 1'b1, "R3 req after tmo", trial_req_o, 1);
      chk(phase_sel_o === expect_ph, "R2 trial phase", phase_sel_o, expect_ph);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        if (poke_start && t == 0 && d == 0) begin
          start_i = 1'b1; cur_phase_i = cur + 3'd4;
        end else start_i = 1'b0;
        chk(!trial_req_o && !tmo_wr_o, "R4 idle while outstanding", trial_req_o, 0);
      end
      @(negedge clk);
      start_i = 1'b0;
      chk(!trial_req_o, "R4 single req", trial_req_o, 0);
      res_vld_i = 1'b1; res_pass_i = map[expect_ph];
      @(negedge clk);
      res_vld_i = 1'b0; res_pass_i = 1'b0;
      if (t == 7) begin
        chk(done_o === 1'b0, "R9 done not early", done_o, 0);
        chk(tmo_wr_o === 1'b0, "R2 no ninth trial", tmo_wr_o, 0);
      end
    end
    @(negedge clk);
    chk(done_o === 1'b1, "R9 done due", done_o, 1);
    chk(err_o === exp_err, exp_err ? "R8 error flag" : "R5/R6/R7 no error", err_o, exp_err);
    chk(phase_sel_o === exp_ph, exp_err ? "R8 phase restored" : "R5/R6/R7 chosen phase",
        phase_sel_o, exp_ph);
    chk(tuned_o === exp_tuned, exp_err ? "R8 tuned kept" : "R9 tuned", tuned_o, exp_tuned);
    @(negedge clk);
    chk(done_o === 1'b0 && err_o === 1'b0, "R9 single pulse", done_o, 0);
    chk(tmo_wr_o === 1'b0 && trial_req_o === 1'b0, "R10 no restart", tmo_wr_o, 0);
    chk(phase_sel_o === exp_ph, "R9 phase held", phase_sel_o, exp_ph);
  endtask

  task automatic t_reset();
    #1;
    chk(phase_sel_o === 3'd0, "R1 phase", phase_sel_o, 0);
    chk(tuned_o === 3'd0, "R1 tuned", tuned_o, 0);
    chk(!tmo_wr_o && !trial_req_o && !done_o && !err_o, "R1 strobes",
        {tmo_wr_o, trial_req_o, done_o, err_o}, 0);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    // R5: all pass -> lowest five-wide centre 0
    sweep(3'd0, 8'hFF, 0, 3'd0, 1'b0, 3'd0, 1'b0);
    // R5 + R10: phases 2..6 pass -> 4, start poked mid-sweep
    sweep(3'd5, 8'h7C, 2, 3'd4, 1'b0, 3'd4, 1'b1);
    // R5 wrap: phases 7,0,1,2,3 -> 1
    sweep(3'd2, 8'h8F, 1, 3'd1, 1'b0, 3'd1, 1'b0);
    // R6: phases 1,5,6,7 -> 6
    sweep(3'd3, 8'hE2, 3, 3'd6, 1'b0, 3'd6, 1'b0);
    // R6 wrap: phases 7,0,1 and 4 -> 0
    sweep(3'd6, 8'h93, 0, 3'd0, 1'b0, 3'd0, 1'b0);
    // R7: phases 3,5 -> 3
    sweep(3'd7, 8'h28, 1, 3'd3, 1'b0, 3'd3, 1'b0);
    // R8: nothing passes, start 6, tuned stays 3
    sweep(3'd6, 8'h00, 2, 3'd6, 1'b1, 3'd3, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule